// File: doc/BRIEF.md
# Stack and control-flow sequencer

This block carries out the branch and stack instructions of a small 8-bit processor with a 16-bit address space. It owns the program counter and the stack pointer. It drives a byte-wide memory port with one access per clock and fetches the little-endian operands that follow an opcode. Its operations are absolute and relative jumps, calls, returns, restarts, and pushes and pops of 16-bit register pairs.

An outside decoder has already consumed the opcode byte, so PC points just past it. The decoder presents an operation class, a conditional flag and the raw opcode. From the opcode the block exposes a 2-bit condition selector, and the decoder answers with a condition-true bit. Register-pair data for pushes enters on a 16-bit input, and popped data leaves on a 16-bit output. A one-cycle completion pulse carries the operation's cycle cost. PC and SP take their new values on that same cycle.

Top module: `flow_seq`

## Requirements
- R1: An absolute jump (class 0) reads the operand low byte at PC and the high byte at PC+1, then loads PC with that 16-bit value. A not-taken one leaves PC at the old PC+2.
- R2: A relative jump (class 1) reads one byte at PC and treats it as signed. When taken it sets PC to PC+1 plus that offset, and when not taken it sets PC to PC+1.
- R3: A push (class 5) writes pair_val bits 7:0 at SP-2 and then bits 15:8 at SP-1, and leaves SP lowered by 2. A restart pushes PC the same way.
- R4: A pop (class 6) reads the low byte at SP and the high byte at SP+1, raises SP by 2 and presents the 16-bit value on pop_val.
- R5: The cycles output reports the cost on completion. Unconditional costs are: relative jump 12, absolute jump 16, call 24, return 16, restart 16, pop 12, push 16. Conditional costs (not taken/taken) are: relative jump 8/12, absolute jump 12/16, call 12/24, return 8/20.
- R6: A call (class 2) fetches a 16-bit operand, pushes PC+2 (the return address) as in R3 and loads PC with the operand. A return (class 3) pops as in R4 into PC.
- R7: A restart (class 4) pushes PC and sets PC to opcode bits 5:3 multiplied by 8 (0x00 to 0x38).
- R8: With is_cond high, the taken path follows cond_ok sampled at start. A not-taken call or return performs no stack access and leaves SP unchanged.
- R9: cond_sel always equals opcode bits 4:3.
- R10: PC and SP wrap modulo 65536 on every step.
- R11: done is a single-cycle pulse that marks the end of each operation, and busy is low in that cycle. A start raised while busy is ignored.
- R12: After reset PC equals RESET_PC, SP equals RESET_SP, and busy, done, mem_rd and mem_wr are low.
- R13: At most one of mem_rd and mem_wr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_class | input | 3 | 0 jump, 1 relative jump, 2 call, 3 return, 4 restart, 5 push, 6 pop |
| is_cond | input | 1 | Operation is conditional |
| cond_ok | input | 1 | Condition is true |
| opcode | input | 8 | Raw opcode byte |
| pair_val | input | 16 | Register pair value to push |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| cond_sel | output | 2 | Condition selector from the opcode |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| cycles | output | 5 | Cost of the completed operation |
| pop_val | output | 16 | Last popped value |

## Verification
The embedded properties watch every cycle for four things. Reads and writes never overlap, and done never lasts two cycles. SP moves only at completion and only by two. Each stack write lands just below the current SP. The bench's scenarios are needed to show target arithmetic, byte order, cycle costs, restart vectors, taken and not-taken routing, and address wrap-around. For these it compares against values it computes from its own memory image.

// File: rtl/flow_seq.sv
module flow_seq #(
  parameter logic [15:0] RESET_PC = 16'h0100,
  parameter logic [15:0] RESET_SP = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op_class,
  input  logic        is_cond,
  input  logic        cond_ok,
  input  logic [7:0]  opcode,
  input  logic [15:0] pair_val,
  input  logic [7:0]  mem_rdata,
  output logic [1:0]  cond_sel,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        busy,
  output logic        done,
  output logic [4:0]  cycles,
  output logic [15:0] pop_val
);
  localparam logic [2:0] C_JP = 3'd0, C_JR = 3'd1, C_CALL = 3'd2, C_RET = 3'd3,
                         C_RST = 3'd4, C_PUSH = 3'd5, C_POP = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_IMM_LO, S_IMM_HI, S_IMM8, S_WR_LO, S_WR_HI, S_RD_LO, S_RD_HI, S_SKIP
  } phase_t;

  phase_t      st;
  logic [2:0]  cls;
  logic [7:0]  opc;
  logic        cnd, tk;
  logic [15:0] tmp, pv;
  logic [4:0]  cost;
  logic        go;
  logic [15:0] word;

  assign cond_sel = opcode[4:3];
  assign busy     = (st != S_IDLE);
  assign go       = !is_cond || cond_ok;
  assign word     = {mem_rdata, tmp[7:0]};

  always_comb begin
    case (cls)
      C_JP:    cost = (cnd && !tk) ? 5'd12 : 5'd16;
      C_JR:    cost = (cnd && !tk) ? 5'd8  : 5'd12;
      C_CALL:  cost = (cnd && !tk) ? 5'd12 : 5'd24;
      C_RET:   cost = cnd ? (tk ? 5'd20 : 5'd8) : 5'd16;
      C_POP:   cost = 5'd12;
      default: cost = 5'd16;
    endcase
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = pc;
    mem_wdata = 8'h00;
    case (st)
      S_IMM_LO, S_IMM_HI, S_IMM8: mem_rd = 1'b1;
      S_WR_LO: begin mem_wr = 1'b1; mem_addr = sp - 16'd2; mem_wdata = pv[7:0];  end
      S_WR_HI: begin mem_wr = 1'b1; mem_addr = sp - 16'd1; mem_wdata = pv[15:8]; end
      S_RD_LO: begin mem_rd = 1'b1; mem_addr = sp; end
      S_RD_HI: begin mem_rd = 1'b1; mem_addr = sp + 16'd1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= RESET_PC; sp <= RESET_SP;
      done <= 1'b0; cycles <= '0; pop_val <= '0;
      cls <= '0; opc <= '0; cnd <= 1'b0; tk <= 1'b0; tmp <= '0; pv <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cls <= op_class;
          opc <= opcode;
          cnd <= is_cond;
          tk  <= go;
          pv  <= (op_class == C_RST) ? pc : pair_val;
          case (op_class)
            C_JP, C_CALL:  st <= S_IMM_LO;
            C_JR:          st <= S_IMM8;
            C_RET:         st <= go ? S_RD_LO : S_SKIP;
            C_RST, C_PUSH: st <= S_WR_LO;
            C_POP:         st <= S_RD_LO;
            default:       st <= S_IDLE;
          endcase
        end
        S_IMM_LO: begin
          tmp[7:0] <= mem_rdata;
          pc <= pc + 16'd1;
          st <= S_IMM_HI;
        end
        S_IMM_HI: begin
          pc <= pc + 16'd1;
          if (tk && cls == C_CALL) begin
            tmp <= word;
            pv  <= pc + 16'd1;
            st  <= S_WR_LO;
          end else begin
            if (tk) pc <= word;
            st <= S_IDLE; done <= 1'b1; cycles <= cost;
          end
        end
        S_IMM8: begin
          pc <= tk ? pc + 16'd1 + {{8{mem_rdata[7]}}, mem_rdata} : pc + 16'd1;
          st <= S_IDLE; done <= 1'b1; cycles <= cost;
        end
        S_WR_LO: st <= S_WR_HI;
        S_WR_HI: begin
          sp <= sp - 16'd2;
          if (cls == C_CALL) pc <= tmp;
          if (cls == C_RST)  pc <= {10'd0, opc[5:3], 3'd0};
          st <= S_IDLE; done <= 1'b1; cycles <= cost;
        end
        S_RD_LO: begin
          tmp[7:0] <= mem_rdata;
          st <= S_RD_HI;
        end
        S_RD_HI: begin
          sp <= sp + 16'd2;
          if (cls == C_RET) pc <= word;
          else pop_val <= word;
          st <= S_IDLE; done <= 1'b1; cycles <= cost;
        end
        default: begin
          st <= S_IDLE; done <= 1'b1; cycles <= cost;
        end
      endcase
    end
  end

  // R13
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R4
  sp_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> (done && (sp == $past(sp) + 16'd2 || sp == $past(sp) - 16'd2)));
  // R3
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == sp - 16'd2 || mem_addr == sp - 16'd1));
endmodule

// File: tb/sim_flow_seq.sv
`timescale 1ns/1ps
module sim_flow_seq;
  logic clk = 0, rst_n = 0, start = 0, is_cond = 0, cond_ok = 0;
  logic [2:0] op_class = 0;
  logic [7:0] opcode = 0;
  logic [15:0] pair_val = 0;
  logic [7:0] mem_rdata, mem_wdata;
  logic [1:0] cond_sel;
  logic [15:0] mem_addr, pc, sp, pop_val;
  logic mem_rd, mem_wr, busy, done;
  logic [4:0] cycles;
  logic [7:0] mem [0:255];
  int n_chk = 0, n_fail = 0;
  logic [15:0] m_pc, m_sp;

  always #2.5 clk = ~clk;

  flow_seq u0 (.clk, .rst_n, .start, .op_class, .is_cond, .cond_ok, .opcode, .pair_val,
    .mem_rdata, .cond_sel, .mem_addr, .mem_rd, .mem_wr, .mem_wdata, .pc, .sp, .busy,
    .done, .cycles, .pop_val);

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_pc = 16'h0100; m_sp = 16'hFFFE;
  endtask

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem[a[7:0]];
  endfunction

  task automatic do_op(input logic [2:0] c, input bit cnd, input bit ok, input logic [7:0] opc,
                       input logic [15:0] pv, input string tg, input bit poke);
    bit tk;
    logic [15:0] epc, esp, imm, val, wv;
    logic [7:0] off;
    logic [4:0] ecost;
    bit wchk, pchk, got;
    tk = !cnd || ok;
    epc = m_pc; esp = m_sp; wchk = 0; pchk = 0; wv = 0; val = 0;
    imm = {rd(m_pc + 16'd1), rd(m_pc)};
    off = rd(m_pc);
    case (c)
      3'd0: begin epc = tk ? imm : m_pc + 16'd2; ecost = cnd ? (tk ? 16 : 12) : 16; end
      3'd1: begin epc = tk ? m_pc + 16'd1 + {{8{off[7]}}, off} : m_pc + 16'd1;
                  ecost = cnd ? (tk ? 12 : 8) : 12; end
      3'd2: begin ecost = cnd ? (tk ? 24 : 12) : 24;
                  if (tk) begin epc = imm; esp = m_sp - 16'd2; wchk = 1; wv = m_pc + 16'd2; end
                  else epc = m_pc + 16'd2; end
      3'd3: begin ecost = cnd ? (tk ? 20 : 8) : 16;
                  if (tk) begin epc = {rd(m_sp + 16'd1), rd(m_sp)}; esp = m_sp + 16'd2; end end
      3'd4: begin ecost = 16; epc = {10'd0, opc[5:3], 3'd0}; esp = m_sp - 16'd2; wchk = 1; wv = m_pc; end
      3'd5: begin ecost = 16; esp = m_sp - 16'd2; wchk = 1; wv = pv; end
      default: begin ecost = 12; esp = m_sp + 16'd2; pchk = 1; val = {rd(m_sp + 16'd1), rd(m_sp)}; end
    endcase
    @(negedge clk);
    op_class = c; is_cond = cnd; cond_ok = ok; opcode = opc; pair_val = pv; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin op_class = 3'd5; pair_val = 16'hDEAD; is_cond = 0; start = 1; end
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
      start = 0;
    end
    chk(got, "R11 watchdog", 0, 1);
    chk(pc == epc, tg, pc, epc);
    chk(sp == esp, tg, sp, esp);
    chk(cycles == ecost, "R5", cycles, ecost);
    chk(!busy, "R11 busy", busy, 0);
    if (wchk) begin
      chk(rd(esp) == wv[7:0], "R3 low byte", rd(esp), wv[7:0]);
      chk(rd(esp + 16'd1) == wv[15:8], "R3 high byte", rd(esp + 16'd1), wv[15:8]);
    end
    if (pchk) chk(pop_val == val, "R4 pop_val", pop_val, val);
    @(negedge clk);
    chk(!done, "R11 pulse", done, 0);
    chk(pc == epc && sp == esp, "R11 ignored start", {pc, sp}, {epc, esp});
    m_pc = epc; m_sp = esp;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    do_reset();
    @(negedge clk);
    // R12
    chk(pc == 16'h0100, "R12 pc", pc, 16'h0100);
    chk(sp == 16'hFFFE, "R12 sp", sp, 16'hFFFE);
    chk(!busy && !done && !mem_rd && !mem_wr, "R12 idle", {busy, done, mem_rd, mem_wr}, 0);
    // R9
    for (int k = 0; k < 256; k += 9) begin
      opcode = 8'(k); #0.1;
      chk(cond_sel == opcode[4:3], "R9", cond_sel, opcode[4:3]);
    end
    // R1
    mem[8'h00] = 8'h34; mem[8'h01] = 8'h12;
    do_op(3'd0, 0, 0, 8'hC3, 0, "R1", 0);
    // R2 offsets sweep
    foreach (mem[i]) ;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] offs [8] = '{8'h00, 8'h05, 8'h7F, 8'h80, 8'hFF, 8'hF0, 8'h01, 8'h81};
      mem[m_pc[7:0]] = offs[k];
      do_op(3'd1, 0, 0, 8'h18, 0, "R2", 0);
    end
    // R6 call and return
    mem[m_pc[7:0]] = 8'h40; mem[8'(m_pc[7:0] + 1)] = 8'h02;
    do_op(3'd2, 0, 0, 8'hCD, 0, "R6 call", 0);
    do_op(3'd3, 0, 0, 8'hC9, 0, "R6 ret", 0);
    // R8 conditional variants
    for (int c = 0; c < 4; c++)
      for (int ok = 0; ok < 2; ok++) begin
        mem[m_pc[7:0]] = 8'h10; mem[8'(m_pc[7:0] + 1)] = 8'h03;
        do_op(3'(c), 1, ok[0], 8'hC2, 0, "R8", 0);
      end
    // R7 restart targets
    for (int k = 0; k < 8; k++) do_op(3'd4, 0, 0, 8'(8'hC7 | (k << 3)), 0, "R7", 0);
    // R3 R4 push/pop patterns
    for (int k = 0; k < 4; k++) do_op(3'd5, 0, 0, 8'hC5, 16'(16'hA55A ^ (k * 16'h1111)), "R3", 0);
    for (int k = 0; k < 4; k++) do_op(3'd6, 0, 0, 8'hC1, 0, "R4", 0);
    // R11 start while busy
    mem[m_pc[7:0]] = 8'h22; mem[8'(m_pc[7:0] + 1)] = 8'h00;
    do_op(3'd0, 0, 0, 8'hC3, 0, "R11 busy start", 1);
    do_op(3'd6, 0, 0, 8'hC1, 0, "R11 busy start", 1);
    // R10 wrap
    do_reset();
    do_op(3'd6, 0, 0, 8'hC1, 0, "R10 sp wrap up", 0);
    do_op(3'd5, 0, 0, 8'hC5, 16'hBEEF, "R10 sp wrap down", 0);
    mem[m_pc[7:0]] = 8'hFE; mem[8'(m_pc[7:0] + 1)] = 8'hFF;
    do_op(3'd0, 0, 0, 8'hC3, 0, "R10 jump high", 0);
    mem[8'hFE] = 8'h03;
    do_op(3'd1, 0, 0, 8'h18, 0, "R10 pc wrap", 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL R11 global watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule